// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the eight-bit status word of a small CPU core and works out its next value each cycle. When an arithmetic or logical result comes out of the datapath, the block receives the operand size, the operation class, the result and the per-bit carry vector. From these it builds the half-carry, sign, zero, overflow and carry flags. Software can replace the whole word with an immediate, or combine it with one through AND, OR or XOR. The current word is always visible on `ccr_q`.

The block also gates interrupts. The mask bit blocks ordinary requests, while a non-maskable request always passes. An exception-entry strobe forces the mask bit on. The sign, zero, overflow and carry flags are also driven as separate outputs for the branch-condition logic.

Each cycle the next value comes from one of four update sources: HOLD, SOFTWARE, ARITH or LOGIC. SOFTWARE is taken whenever a software operation is present. Otherwise ARITH or LOGIC is taken when `flag_we` is high and the class matches. Otherwise HOLD keeps the word. An exception entry is then laid over the chosen source and sets bit 7.

Top module: `ccr_unit`

## Requirements
- R1: After reset, `ccr_q` reads 0x80: the mask bit is 1 and all other bits are 0.
- R2: The bit layout of `ccr_q` is mask I at bit 7, user bit UI at 6, half-carry H at 5, user bit U at 4, N at 3, Z at 2, V at 1 and C at 0. `flag_n`, `flag_z`, `flag_v` and `flag_c` always equal bits 3, 2, 1 and 0.
- R3: When `exc_entry` is high, bit 7 is 1 after the next clock edge. This holds even when a software operation occurs in the same cycle; the other bits follow that operation.
- R4: `irq_accept` is combinational and equals `irq_req & (irq_nmi | ~ccr_q[7])`.
- R5: Size codes are 0 byte, 1 word and 2 long; code 3 acts as long. For class 0 (arithmetic), H takes carry-vector bit 3, 11 or 27 for byte, word or long.
- R6: For classes 0 and 1, N takes result bit 7, 15 or 31 at the active size. Z is 1 only when the result bits below the size width are all zero; bits above that width are ignored.
- R7: `carry_vec[k]` is the carry or borrow out of bit k. For class 0, C takes `carry_vec[msb]` and V takes `carry_vec[msb] ^ carry_vec[msb-1]`.
- R8: For class 1 (logical or move), N and Z are updated, V is cleared, and H, C, I, UI and U keep their values.
- R9: When `flag_we` is low, or the class is 2 or 3, the ALU inputs leave `ccr_q` unchanged.
- R10: Software operation codes are 0 none, 1 load, 2 AND, 3 OR and 4 XOR; codes 5 to 7 act as none. The operation applies to the whole word with `sw_imm` at the next edge. A software operation overrides any ALU flag update in the same cycle.
- R11: UI (bit 6) and U (bit 4) change only through a software operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_size | input | 2 | Operand size code |
| alu_class | input | 2 | Operation class code |
| flag_we | input | 1 | Flag update enable |
| alu_result | input | 32 | ALU result |
| carry_vec | input | 32 | Per-bit carry/borrow out |
| sw_op | input | 3 | Software operation code |
| sw_imm | input | 8 | Software immediate |
| exc_entry | input | 1 | Exception-entry strobe |
| irq_req | input | 1 | Interrupt request |
| irq_nmi | input | 1 | Request is non-maskable |
| ccr_q | output | 8 | Register value |
| irq_accept | output | 1 | Interrupt accepted |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
An exception entry and a software write can happen in the same cycle, and the two then compete for bit 7. The bench raises `exc_entry` together with a load of 0x00. It expects 0x80, so the mask comes from the exception while every other bit comes from the load. In a second same-cycle case, a load of 0x55 is issued together with an arithmetic update that would set Z. The result must be exactly 0x55, which shows that the software path wins.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int CCR_W  = 8;
    localparam int DATA_W = 32;
    localparam int BIT_I  = 7;
    localparam int BIT_UI = 6;
    localparam int BIT_H  = 5;
    localparam int BIT_U  = 4;
    localparam int BIT_N  = 3;
    localparam int BIT_Z  = 2;
    localparam int BIT_V  = 1;
    localparam int BIT_C  = 0;
    // half-carry sits four bits below the sign bit at every size
    localparam int HC_BELOW_MSB = 4;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} opsize_e;
    typedef enum logic [1:0] {CLS_ARITH = 2'd0, CLS_LOGIC = 2'd1, CLS_NONE = 2'd2, CLS_RSVD = 2'd3} opclass_e;
    typedef enum logic [2:0] {SW_NONE = 3'd0, SW_LOAD = 3'd1, SW_AND = 3'd2, SW_OR = 3'd3,
                              SW_XOR = 3'd4, SW_R5 = 3'd5, SW_R6 = 3'd6, SW_R7 = 3'd7} swop_e;
    typedef enum logic [1:0] {UPD_HOLD, UPD_SOFTWARE, UPD_ARITH, UPD_LOGIC} upd_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] result_i,
    input  logic [DW-1:0] carry_i,
    output alu_flags_t    flags_o
);
    localparam int MSB_IDX_W = $clog2(DW);

    logic [MSB_IDX_W-1:0] msb;
    logic [DW-1:0]        width_mask;
    logic                 zero;

    always_comb begin
        unique case (opsize_e'(size_i))
            SZ_BYTE: msb = MSB_IDX_W'(7);
            SZ_WORD: msb = MSB_IDX_W'(15);
            default: msb = MSB_IDX_W'(DW - 1);
        endcase
    end

    // mask of the bits that belong to the active size
    for (genvar k = 0; k < DW; k++) begin : g_mask
        assign width_mask[k] = (k <= int'(msb));
    end

    assign zero = ((result_i & width_mask) == '0);

    always_comb begin
        flags_o.h = carry_i[msb - MSB_IDX_W'(HC_BELOW_MSB)];
        flags_o.n = result_i[msb];
        flags_o.z = zero;
        flags_o.c = carry_i[msb];
        flags_o.v = carry_i[msb] ^ carry_i[msb - MSB_IDX_W'(1)];
    end

    // R6: a value that is zero at the size cannot have its sign bit set
    always_comb begin
        assert_zero_not_neg_R6: assert (!(flags_o.z && flags_o.n));
    end
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
    input  logic mask_i,
    input  logic req_i,
    input  logic nmi_i,
    output logic accept_o
);
    assign accept_o = req_i & (nmi_i | ~mask_i);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  alu_size,
    input  logic [1:0]  alu_class,
    input  logic        flag_we,
    input  logic [31:0] alu_result,
    input  logic [31:0] carry_vec,
    input  logic [2:0]  sw_op,
    input  logic [7:0]  sw_imm,
    input  logic        exc_entry,
    input  logic        irq_req,
    input  logic        irq_nmi,
    output logic [7:0]  ccr_q,
    output logic        irq_accept,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c
);
    localparam logic [CCR_W-1:0] CCR_RESET = CCR_W'(1) << BIT_I;

    alu_flags_t       alu_flags;
    upd_e             upd_sel;
    logic             sw_active;
    logic [CCR_W-1:0] ccr_d;

    ccr_flag_calc #(.DW(DATA_W)) u_flags (
        .size_i  (alu_size),
        .result_i(alu_result),
        .carry_i (carry_vec),
        .flags_o (alu_flags)
    );

    ccr_irq_gate u_irq (
        .mask_i  (ccr_q[BIT_I]),
        .req_i   (irq_req),
        .nmi_i   (irq_nmi),
        .accept_o(irq_accept)
    );

    assign sw_active = (sw_op >= 3'(SW_LOAD)) && (sw_op <= 3'(SW_XOR));

    // choose the update source
    always_comb begin
        if (sw_active)
            upd_sel = UPD_SOFTWARE;
        else if (flag_we && opclass_e'(alu_class) == CLS_ARITH)
            upd_sel = UPD_ARITH;
        else if (flag_we && opclass_e'(alu_class) == CLS_LOGIC)
            upd_sel = UPD_LOGIC;
        else
            upd_sel = UPD_HOLD;
    end

    // next value of the word
    always_comb begin
        ccr_d = ccr_q;
        unique case (upd_sel)
            UPD_SOFTWARE: begin
                unique case (swop_e'(sw_op))
                    SW_LOAD: ccr_d = sw_imm;
                    SW_AND:  ccr_d = ccr_q & sw_imm;
                    SW_OR:   ccr_d = ccr_q | sw_imm;
                    SW_XOR:  ccr_d = ccr_q ^ sw_imm;
                    default: ccr_d = ccr_q;
                endcase
            end
            UPD_ARITH: begin
                ccr_d[BIT_H] = alu_flags.h;
                ccr_d[BIT_N] = alu_flags.n;
                ccr_d[BIT_Z] = alu_flags.z;
                ccr_d[BIT_V] = alu_flags.v;
                ccr_d[BIT_C] = alu_flags.c;
            end
            UPD_LOGIC: begin
                ccr_d[BIT_N] = alu_flags.n;
                ccr_d[BIT_Z] = alu_flags.z;
                ccr_d[BIT_V] = 1'b0;
            end
            UPD_HOLD: ccr_d = ccr_q;
            default:  ccr_d = ccr_q;
        endcase
        if (exc_entry) ccr_d[BIT_I] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ccr_q <= CCR_RESET;
        else        ccr_q <= ccr_d;
    end

    assign flag_n = ccr_q[BIT_N];
    assign flag_z = ccr_q[BIT_Z];
    assign flag_v = ccr_q[BIT_V];
    assign flag_c = ccr_q[BIT_C];

    assert_exc_sets_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> ccr_q[BIT_I]);

    assert_nmi_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_nmi) |-> irq_accept);

    assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_nmi && ccr_q[BIT_I]) |-> !irq_accept);

    assert_user_bits_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_active |=> (ccr_q[BIT_UI] == $past(ccr_q[BIT_UI])) && (ccr_q[BIT_U] == $past(ccr_q[BIT_U])));

    assert_logic_clears_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_active && flag_we && alu_class == 2'd1) |=> !ccr_q[BIT_V]);
endmodule

// File: tb/tb_ccr_unit.sv
module tb_ccr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alu_size = '0;
    logic [1:0]  alu_class = 2'd2;
    logic        flag_we = 1'b0;
    logic [31:0] alu_result = '0;
    logic [31:0] carry_vec = '0;
    logic [2:0]  sw_op = '0;
    logic [7:0]  sw_imm = '0;
    logic        exc_entry = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_nmi = 1'b0;
    logic [7:0]  ccr_q;
    logic        irq_accept, flag_n, flag_z, flag_v, flag_c;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ccr_unit dut (.*);

    // {sw_op, sw_imm, flag_we, class, size, result, carry_vec, expected ccr}
    localparam int NV = 14;
    localparam logic [87:0] VEC [NV] = '{
        {3'd1, 8'h00, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h00}, // R10 load
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd0, 32'h0000_0080, 32'h0000_0008, 8'h28}, // R5 R6 byte H,N
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd0, 32'hFFFF_FF00, 32'h0000_0080, 8'h07}, // R6 R7 byte Z,V,C
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd1, 32'h0000_8000, 32'h0000_C800, 8'h29}, // R5 R7 word
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd2, 32'h0000_0000, 32'h4800_0000, 8'h26}, // R5 R7 long
        {3'd0, 8'h00, 1'b1, 2'd1, 2'd0, 32'h0000_0001, 32'h0000_0000, 8'h20}, // R8 logic
        {3'd3, 8'h50, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h70}, // R10 or
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 8'h79}, // R7 R11 long
        {3'd0, 8'h00, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h79}, // R9 we low
        {3'd4, 8'hFF, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h86}, // R10 xor
        {3'd2, 8'h0F, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h06}, // R10 and
        {3'd1, 8'h55, 1'b1, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h55}, // R10 priority
        {3'd0, 8'h00, 1'b1, 2'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 8'h55}, // R9 class none
        {3'd0, 8'h00, 1'b1, 2'd0, 2'd1, 32'hABCD_0000, 32'h0000_0000, 8'h54}  // R6 R11 upper ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sw_op = '0; sw_imm = '0; flag_we = 1'b0; alu_class = 2'd2;
        exc_entry = 1'b0; irq_req = 1'b0; irq_nmi = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {24'h0, ccr_q}, 32'h80);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'h0, ccr_q}, 32'h80);

        for (int i = 0; i < NV; i++) begin
            {sw_op, sw_imm, flag_we, alu_class, alu_size, alu_result, carry_vec} = VEC[i][87:8];
            @(negedge clk);
            check($sformatf("R2 vec %0d", i), {24'h0, ccr_q}, {24'h0, VEC[i][7:0]});
            check($sformatf("R2 flags vec %0d", i), {28'h0, flag_n, flag_z, flag_v, flag_c},
                  {28'h0, VEC[i][3:0]});
        end
        idle();

        // exception alone from 0x54
        exc_entry = 1'b1;
        @(negedge clk);
        check("R3 exc alone", {24'h0, ccr_q}, 32'hD4);
        // exception together with a load of 0x00
        sw_op = 3'd1; sw_imm = 8'h00;
        @(negedge clk);
        check("R3 exc with load", {24'h0, ccr_q}, 32'h80);
        idle();

        // interrupt gating, mask currently 1
        irq_req = 1'b1; #1;
        check("R4 masked", {31'h0, irq_accept}, 32'h0);
        irq_nmi = 1'b1; #1;
        check("R4 nmi", {31'h0, irq_accept}, 32'h1);
        irq_req = 1'b0; #1;
        check("R4 no req", {31'h0, irq_accept}, 32'h0);
        idle();
        sw_op = 3'd1; sw_imm = 8'h00;
        @(negedge clk);
        idle();
        irq_req = 1'b1; #1;
        check("R4 unmasked", {31'h0, irq_accept}, 32'h1);
        idle();

        // reserved software code acts as none
        sw_op = 3'd6; sw_imm = 8'hFF;
        @(negedge clk);
        check("R10 reserved op", {24'h0, ccr_q}, 32'h00);
        idle();

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule